// File: doc/BRIEF.md
# Interrupt Acknowledge and Output Routing Unit

This block sits next to the priority search of a multiprocessor interrupt controller and handles the moment a target takes an interrupt. The search logic supplies the index of the best raised source for a target. When that target performs an acknowledge read, the unit decides in the same cycle whether the source is still worth delivering. The source must still be active, and its priority must be strictly above the target's current task priority. The unit then returns either the source's vector or a configurable spurious vector. On the clock edge that ends the read, it applies the side effects to the source and target state.

Sources can be edge- or level-sensitive. Some sources are inter-processor sources that may be aimed at several targets at once. For those, each acknowledge removes only the reading target from the destination mask. If an edge source still has targets left, it is fired again for them, and the unit flags this to the search logic. When a source is raised towards a target, the unit also chooses which of the target's two lines it drives: the critical line or the ordinary one.

Top module: `irq_ack_unit`

## Requirements
- R1: With `ack_src` below N_SRC, the source active, and its 5-bit priority strictly greater than the target's zero-extended 4-bit task priority, `ack_vec` shows the source vector and `ack_spur` is 0 in the same cycle. After the edge that ends an `ack_rd` cycle, `svc_vld[t]` is 1 and the target's `svc_src` field holds the source index.
- R2: With a valid index, an inactive source or a priority not above the task priority gives `spur_vec` on `ack_vec` with `ack_spur`=1. An `ack_rd` in that case clears the source's active bit, unless R6 re-fires the source, and leaves `svc_src` unchanged.
- R3: An `ack_src` of N_SRC or more means "no interrupt". It gives `spur_vec` with `ack_spur`=1, and an `ack_rd` with it leaves active, pending, raised and destination state unchanged.
- R4: Every `ack_rd` by target t clears `tgt_next_vld[t]`, `irq_norm[t]` and `irq_crit[t]`. With a valid index it also clears raised bit t*N_SRC+s.
- R5: An acknowledge of an edge source (`cfg_level` bit 0) clears both its active and pending bits. A valid acknowledge of a level source leaves both unchanged.
- R6: An acknowledge of a source marked in `cfg_ipi` clears destination bit t. If any of destination bits [N_TGT-1:0] are still set afterwards and the source is edge-sensitive, `retrig_vld`=1 and `retrig_src`=s in that cycle, and the source ends with active and pending both set.
- R7: A raise of source s to target t sets the source's active bit, raised bit t*N_SRC+s and `tgt_next_vld[t]`. It drives `irq_crit[t]` when `crit_en` is set and destination bit (30 - t) of the source is 1, and drives `irq_norm[t]` otherwise. Only one of the two lines is high at a time.
- R8: `trig_vld` sets the pending bit of source `trig_src`, and `dest_wr` loads `dest_data` into the destination word of source `dest_sel`.
- R9: After reset, all source state, raised bits, next-index flags, output lines and in-service flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_prio | input | N_SRC*5 | source s priority in bits [5s+4:5s] |
| cfg_vec | input | N_SRC*VEC_W | source s vector in field s |
| cfg_level | input | N_SRC | 1 = level-sensitive source |
| cfg_ipi | input | N_SRC | 1 = inter-processor source |
| spur_vec | input | VEC_W | vector returned for spurious acknowledges |
| crit_en | input | 1 | enables routing to the critical lines |
| tgt_ctp | input | N_TGT*4 | target t task priority in bits [4t+3:4t] |
| dest_wr | input | 1 | destination word load strobe |
| dest_sel | input | SRC_W | source whose destination word is loaded |
| dest_data | input | DEST_W | destination word; bit t = target, bit 30-t = critical for t |
| trig_vld | input | 1 | set pending strobe |
| trig_src | input | SRC_W | source to mark pending |
| raise_vld | input | 1 | raise strobe from the routing logic |
| raise_tgt | input | TGT_W | target being raised |
| raise_src | input | SRC_W | source being raised |
| ack_rd | input | 1 | acknowledge read strobe |
| ack_tgt | input | TGT_W | reading target |
| ack_src | input | SRC_W | best raised source for the target; N_SRC = none |
| ack_vec | output | VEC_W | returned vector |
| ack_spur | output | 1 | returned vector is the spurious one |
| retrig_vld | output | 1 | source re-fired for the remaining targets |
| retrig_src | output | SRC_W | source that was re-fired |
| src_active | output | N_SRC | per-source active bits |
| src_pending | output | N_SRC | per-source pending bits |
| src_dest | output | N_SRC*DEST_W | per-source destination words |
| tgt_raised | output | N_TGT*N_SRC | raised bit t*N_SRC+s |
| tgt_next_vld | output | N_TGT | target's cached next index is valid |
| irq_norm | output | N_TGT | ordinary interrupt lines |
| irq_crit | output | N_TGT | critical interrupt lines |
| svc_vld | output | N_TGT | target has a source in service |
| svc_src | output | N_TGT*IW | in-service source of target t |

## Verification
The validity decision is swept over every pair of source priority and task priority. This separates a strict comparison from a non-strict one and checks the zero-extension of the task priority. Every source and target is then acknowledged under each of the four combinations of edge or level and ordinary or inter-processor. Inter-processor sources are tried both with other targets left in the destination mask and with none left, which tells re-firing apart from plain clearing. Crit-enable and the critical bit are alternated to exercise both output lines. Spurious cases cover a priority below the task priority, a priority equal to it, an inactive source and the no-interrupt index, so the side effects of each path can be compared.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int unsigned PRI_W    = 5;
  localparam int unsigned CTP_W    = 4;
  localparam int unsigned CRIT_TOP = 30;

  // a source is deliverable when active and strictly above the task level
  function automatic logic ack_valid(input logic act,
                                     input logic [PRI_W-1:0] prio,
                                     input logic [CTP_W-1:0] ctp);
    return act && (prio > {{(PRI_W-CTP_W){1'b0}}, ctp});
  endfunction

  // destination bit that routes target tgt to its critical line
  function automatic int unsigned crit_pos(input int unsigned tgt);
    return CRIT_TOP - tgt;
  endfunction
endpackage

// File: rtl/intack_decide.sv
module intack_decide import intack_pkg::*; #(
  parameter int unsigned N_TGT = 4,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned DEST_W = 32,
  localparam int unsigned TGT_W = $clog2(N_TGT)
) (
  input  logic              idx_ok,
  input  logic              act,
  input  logic [PRI_W-1:0]  prio,
  input  logic [CTP_W-1:0]  ctp,
  input  logic              level,
  input  logic              ipi,
  input  logic [DEST_W-1:0] dest,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [VEC_W-1:0]  vec,
  input  logic [VEC_W-1:0]  spur,
  output logic              ok,
  output logic [VEC_W-1:0]  vec_out,
  output logic              rerun,
  output logic [DEST_W-1:0] clr_mask
);
  logic [N_TGT-1:0] left;

  assign ok       = idx_ok && ack_valid(act, prio, ctp);
  assign vec_out  = ok ? vec : spur;
  assign clr_mask = DEST_W'(1) << tgt;
  assign left     = dest[N_TGT-1:0] & ~(N_TGT'(1) << tgt);
  assign rerun    = idx_ok && ipi && !level && (|left);
endmodule

// File: rtl/intack_src.sv
module intack_src #(
  parameter int unsigned DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dest_ld,
  input  logic [DEST_W-1:0] dest_in,
  input  logic              trig,
  input  logic              raise,
  input  logic              ack_hit,
  input  logic              ack_ok,
  input  logic              ack_level,
  input  logic              ack_ipi,
  input  logic              ack_rerun,
  input  logic [DEST_W-1:0] ack_clr,
  output logic              active,
  output logic              pending,
  output logic [DEST_W-1:0] dest
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
      dest    <= '0;
    end else begin
      if (dest_ld) dest <= dest_in;
      if (trig) pending <= 1'b1;
      if (raise) active <= 1'b1;
      // acknowledge effects come last so they win over same-cycle events
      if (ack_hit) begin
        if (!ack_ok || !ack_level) active <= 1'b0;
        if (!ack_level) pending <= 1'b0;
        if (ack_ipi) dest <= dest & ~ack_clr;
        if (ack_rerun) begin
          active  <= 1'b1;
          pending <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/intack_tgt.sv
module intack_tgt #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_hit,
  input  logic [IW-1:0]    raise_idx,
  input  logic             raise_crit,
  input  logic             ack_hit,
  input  logic             ack_idx_ok,
  input  logic [IW-1:0]    ack_idx,
  input  logic             ack_ok,
  output logic [N_SRC-1:0] raised,
  output logic             next_vld,
  output logic             line_n,
  output logic             line_c,
  output logic             svc_vld,
  output logic [IW-1:0]    svc_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised   <= '0;
      next_vld <= 1'b0;
      line_n   <= 1'b0;
      line_c   <= 1'b0;
      svc_vld  <= 1'b0;
      svc_idx  <= '0;
    end else begin
      if (raise_hit) begin
        raised[raise_idx] <= 1'b1;
        next_vld <= 1'b1;
        line_c <= raise_crit;
        line_n <= !raise_crit;
      end
      if (ack_hit) begin
        if (ack_idx_ok) raised[ack_idx] <= 1'b0;
        next_vld <= 1'b0;
        line_n   <= 1'b0;
        line_c   <= 1'b0;
        if (ack_ok) begin
          svc_vld <= 1'b1;
          svc_idx <= ack_idx;
        end
      end
    end
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit import intack_pkg::*; #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned N_TGT  = 4,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned DEST_W = 32,
  localparam int unsigned SRC_W = $clog2(N_SRC + 1),
  localparam int unsigned TGT_W = $clog2(N_TGT),
  localparam int unsigned IW    = $clog2(N_SRC),
  localparam int unsigned DW_W  = $clog2(DEST_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC*PRI_W-1:0]  cfg_prio,
  input  logic [N_SRC*VEC_W-1:0]  cfg_vec,
  input  logic [N_SRC-1:0]        cfg_level,
  input  logic [N_SRC-1:0]        cfg_ipi,
  input  logic [VEC_W-1:0]        spur_vec,
  input  logic                    crit_en,
  input  logic [N_TGT*CTP_W-1:0]  tgt_ctp,
  input  logic                    dest_wr,
  input  logic [SRC_W-1:0]        dest_sel,
  input  logic [DEST_W-1:0]       dest_data,
  input  logic                    trig_vld,
  input  logic [SRC_W-1:0]        trig_src,
  input  logic                    raise_vld,
  input  logic [TGT_W-1:0]        raise_tgt,
  input  logic [SRC_W-1:0]        raise_src,
  input  logic                    ack_rd,
  input  logic [TGT_W-1:0]        ack_tgt,
  input  logic [SRC_W-1:0]        ack_src,
  output logic [VEC_W-1:0]        ack_vec,
  output logic                    ack_spur,
  output logic                    retrig_vld,
  output logic [SRC_W-1:0]        retrig_src,
  output logic [N_SRC-1:0]        src_active,
  output logic [N_SRC-1:0]        src_pending,
  output logic [N_SRC*DEST_W-1:0] src_dest,
  output logic [N_TGT*N_SRC-1:0]  tgt_raised,
  output logic [N_TGT-1:0]        tgt_next_vld,
  output logic [N_TGT-1:0]        irq_norm,
  output logic [N_TGT-1:0]        irq_crit,
  output logic [N_TGT-1:0]        svc_vld,
  output logic [N_TGT*IW-1:0]     svc_src
);
  // named internal events
  logic              idx_ok, raise_ok, ack_ok_w, rerun, a_level, a_ipi, r_crit;
  logic [IW-1:0]     a_i, r_i;
  logic [DEST_W-1:0] dest_q [N_SRC];
  logic [DEST_W-1:0] clr_mask;
  logic [DW_W-1:0]   cpos;

  assign idx_ok   = ack_src < SRC_W'(N_SRC);
  assign raise_ok = raise_vld && (raise_src < SRC_W'(N_SRC));
  assign a_i      = idx_ok ? ack_src[IW-1:0] : '0;
  assign r_i      = raise_src[IW-1:0];
  assign a_level  = cfg_level[a_i];
  assign a_ipi    = cfg_ipi[a_i];
  assign cpos     = DW_W'(crit_pos(32'(raise_tgt)));
  assign r_crit   = crit_en && dest_q[r_i][cpos];

  intack_decide #(.N_TGT(N_TGT), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_dec (
    .idx_ok  (idx_ok),
    .act     (src_active[a_i]),
    .prio    (cfg_prio[a_i*PRI_W +: PRI_W]),
    .ctp     (tgt_ctp[ack_tgt*CTP_W +: CTP_W]),
    .level   (a_level),
    .ipi     (a_ipi),
    .dest    (dest_q[a_i]),
    .tgt     (ack_tgt),
    .vec     (cfg_vec[a_i*VEC_W +: VEC_W]),
    .spur    (spur_vec),
    .ok      (ack_ok_w),
    .vec_out (ack_vec),
    .rerun   (rerun),
    .clr_mask(clr_mask)
  );

  assign ack_spur   = !ack_ok_w;
  assign retrig_vld = ack_rd && rerun;
  assign retrig_src = ack_src;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    intack_src #(.DEST_W(DEST_W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .dest_ld  (dest_wr && dest_sel == SRC_W'(s)),
      .dest_in  (dest_data),
      .trig     (trig_vld && trig_src == SRC_W'(s)),
      .raise    (raise_ok && r_i == IW'(s)),
      .ack_hit  (ack_rd && idx_ok && a_i == IW'(s)),
      .ack_ok   (ack_ok_w),
      .ack_level(a_level),
      .ack_ipi  (a_ipi),
      .ack_rerun(rerun),
      .ack_clr  (clr_mask),
      .active   (src_active[s]),
      .pending  (src_pending[s]),
      .dest     (dest_q[s])
    );
    assign src_dest[s*DEST_W +: DEST_W] = dest_q[s];
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    intack_tgt #(.N_SRC(N_SRC)) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise_hit (raise_ok && raise_tgt == TGT_W'(t)),
      .raise_idx (r_i),
      .raise_crit(r_crit),
      .ack_hit   (ack_rd && ack_tgt == TGT_W'(t)),
      .ack_idx_ok(idx_ok),
      .ack_idx   (a_i),
      .ack_ok    (ack_ok_w),
      .raised    (tgt_raised[t*N_SRC +: N_SRC]),
      .next_vld  (tgt_next_vld[t]),
      .line_n    (irq_norm[t]),
      .line_c    (irq_crit[t]),
      .svc_vld   (svc_vld[t]),
      .svc_idx   (svc_src[t*IW +: IW])
    );
  end
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_TGT = 4,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned SRC_W = $clog2(N_SRC + 1),
  localparam int unsigned TGT_W = $clog2(N_TGT),
  localparam int unsigned IW    = $clog2(N_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_rd,
  input logic [TGT_W-1:0]   ack_tgt,
  input logic [SRC_W-1:0]   ack_src,
  input logic               ack_idx_ok,
  input logic               ack_ok,
  input logic               ack_level,
  input logic               ack_ipi,
  input logic               ack_rerun,
  input logic [VEC_W-1:0]   ack_vec,
  input logic               ack_spur,
  input logic [VEC_W-1:0]   spur_vec,
  input logic               retrig_vld,
  input logic               raise_vld,
  input logic               trig_vld,
  input logic               dest_wr,
  input logic [N_SRC-1:0]   src_active,
  input logic [N_SRC-1:0]   src_pending,
  input logic [N_TGT-1:0]   tgt_next_vld,
  input logic [N_TGT-1:0]   irq_norm,
  input logic [N_TGT-1:0]   irq_crit,
  input logic [N_TGT-1:0]   svc_vld,
  input logic [N_TGT*IW-1:0] svc_src
);
  logic             l_rd, l_fire, l_edge, l_none, l_rerun;
  logic [TGT_W-1:0] l_tgt;
  logic [IW-1:0]    l_src;
  logic [N_SRC-1:0] l_act, l_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rd <= 1'b0; l_fire <= 1'b0; l_edge <= 1'b0; l_none <= 1'b0; l_rerun <= 1'b0;
      l_tgt <= '0; l_src <= '0; l_act <= '0; l_pend <= '0;
    end else begin
      l_rd    <= ack_rd;
      l_fire  <= ack_rd && ack_ok;
      l_edge  <= ack_rd && ack_idx_ok && !ack_level && !ack_ipi;
      l_none  <= ack_rd && !ack_idx_ok && !raise_vld && !trig_vld && !dest_wr;
      l_rerun <= ack_rd && ack_rerun;
      l_tgt   <= ack_tgt;
      l_src   <= ack_src[IW-1:0];
      l_act   <= src_active;
      l_pend  <= src_pending;
    end
  end

  a_r1_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    l_fire |-> svc_vld[l_tgt] && svc_src[l_tgt*IW +: IW] == l_src);
  a_r2_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && ack_idx_ok && !ack_ok |-> ack_spur && ack_vec == spur_vec);
  a_r3_none_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    l_none |-> src_active == l_act && src_pending == l_pend);
  a_r4_ack_clears_target: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |-> !tgt_next_vld[l_tgt] && !irq_norm[l_tgt] && !irq_crit[l_tgt]);
  a_r5_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    l_edge |-> !src_active[l_src] && !src_pending[l_src]);
  a_r6_refire_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && ack_rerun |-> retrig_vld);
  a_r6_refire_state: assert property (@(posedge clk) disable iff (!rst_n)
    l_rerun |-> src_active[l_src] && src_pending[l_src]);
  a_r7_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(irq_norm & irq_crit)));
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.N_SRC(N_SRC), .N_TGT(N_TGT), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .ack_tgt(ack_tgt), .ack_src(ack_src),
  .ack_idx_ok(idx_ok), .ack_ok(ack_ok_w), .ack_level(a_level), .ack_ipi(a_ipi),
  .ack_rerun(rerun), .ack_vec(ack_vec), .ack_spur(ack_spur), .spur_vec(spur_vec),
  .retrig_vld(retrig_vld), .raise_vld(raise_vld), .trig_vld(trig_vld), .dest_wr(dest_wr),
  .src_active(src_active), .src_pending(src_pending), .tgt_next_vld(tgt_next_vld),
  .irq_norm(irq_norm), .irq_crit(irq_crit), .svc_vld(svc_vld), .svc_src(svc_src)
);

// File: tb/irq_ack_unit_test.sv
`timescale 1ns/1ps
module irq_ack_unit_test;
  localparam int NS = 8, NT = 4, VW = 8, DW = 32, SW = 4, TW = 2, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS*5-1:0]  cfg_prio = '0;
  logic [NS*VW-1:0] cfg_vec = '0;
  logic [NS-1:0]    cfg_level = '0, cfg_ipi = '0;
  logic [VW-1:0]    spur_vec = 8'hFF;
  logic             crit_en = 1'b0;
  logic [NT*4-1:0]  tgt_ctp = '0;
  logic             dest_wr = 1'b0, trig_vld = 1'b0, raise_vld = 1'b0, ack_rd = 1'b0;
  logic [SW-1:0]    dest_sel = '0, trig_src = '0, raise_src = '0, ack_src = '0;
  logic [DW-1:0]    dest_data = '0;
  logic [TW-1:0]    raise_tgt = '0, ack_tgt = '0;
  logic [VW-1:0]    ack_vec;
  logic             ack_spur, retrig_vld;
  logic [SW-1:0]    retrig_src;
  logic [NS-1:0]    src_active, src_pending;
  logic [NS*DW-1:0] src_dest;
  logic [NT*NS-1:0] tgt_raised;
  logic [NT-1:0]    tgt_next_vld, irq_norm, irq_crit, svc_vld;
  logic [NT*IW-1:0] svc_src;

  int n_chk = 0, n_fail = 0;

  irq_ack_unit uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    dest_wr = 0; trig_vld = 0; raise_vld = 0; ack_rd = 0;
  endtask

  task automatic load_dest(input int s, input logic [DW-1:0] d);
    dest_wr = 1; dest_sel = SW'(s); dest_data = d; step();
  endtask
  task automatic do_trig(input int s);
    trig_vld = 1; trig_src = SW'(s); step();
  endtask
  task automatic do_raise(input int t, input int s);
    raise_vld = 1; raise_tgt = TW'(t); raise_src = SW'(s); step();
  endtask
  task automatic set_src(input int s, input int p, input logic lv, input logic ip);
    cfg_prio[s*5 +: 5] = 5'(p); cfg_level[s] = lv; cfg_ipi[s] = ip;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) cfg_vec[s*VW +: VW] = VW'(8'h40 + s);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 active", 64'(src_active), 0);
    check("R9 pending", 64'(src_pending), 0);
    check("R9 raised", 64'(tgt_raised), 0);
    check("R9 lines", 64'({irq_norm, irq_crit, tgt_next_vld, svc_vld}), 0);
    rst_n = 1;
    step();

    // R1 R2 comparison sweep: source 0 active, no read strobe
    set_src(0, 1, 1'b1, 1'b0);
    do_raise(0, 0);
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 16; c++) begin
        cfg_prio[4:0] = 5'(p); tgt_ctp[3:0] = 4'(c); ack_tgt = 0; ack_src = 0;
        #0.5;
        check(p > c ? "R1 spur flag" : "R2 spur flag", 64'(ack_spur), 64'(p <= c));
        check(p > c ? "R1 vector" : "R2 vector", 64'(ack_vec), p > c ? 64'h40 : 64'hFF);
      end
    end
    tgt_ctp = '0;

    // R1 R4 R5 R6 R7 R8 scenarios over every source, target and mode
    for (int s = 0; s < NS; s++) begin
      for (int t = 0; t < NT; t++) begin
        for (int m = 0; m < 4; m++) begin
          logic lv, ip, cb, ce, multi, refire;
          logic [DW-1:0] d;
          lv = m[0]; ip = m[1]; cb = s[1]; ce = 1'((s + t) % 2);
          multi = ip && (s % 2 == 0);
          refire = multi && !lv;
          d = (multi ? 32'hF : (32'h1 << t)) | (32'(cb) << (30 - t));
          set_src(s, 16 + s, lv, ip); crit_en = ce;
          load_dest(s, d);
          check("R8 dest load", 64'(src_dest[s*DW +: DW]), 64'(d));
          do_trig(s);
          check("R8 pending set", 64'(src_pending[s]), 1);
          do_raise(t, s);
          check("R7 active", 64'(src_active[s]), 1);
          check("R7 raised", 64'(tgt_raised[t*NS+s]), 1);
          check("R7 next", 64'(tgt_next_vld[t]), 1);
          check("R7 crit line", 64'(irq_crit[t]), 64'(ce && cb));
          check("R7 norm line", 64'(irq_norm[t]), 64'(!(ce && cb)));
          ack_rd = 1; ack_tgt = TW'(t); ack_src = SW'(s);
          #0.5;
          check("R1 vector", 64'(ack_vec), 64'(8'h40 + s));
          check("R1 spur", 64'(ack_spur), 0);
          check("R6 retrig flag", 64'(retrig_vld), 64'(refire));
          if (refire) check("R6 retrig src", 64'(retrig_src), 64'(s));
          step();
          check("R4 raised clr", 64'(tgt_raised[t*NS+s]), 0);
          check("R4 next clr", 64'(tgt_next_vld[t]), 0);
          check("R4 lines clr", 64'({irq_norm[t], irq_crit[t]}), 0);
          check("R1 svc", 64'({svc_vld[t], svc_src[t*IW +: IW]}), 64'({1'b1, 3'(s)}));
          check(ip ? "R6 active" : "R5 active", 64'(src_active[s]), 64'(lv || refire));
          check(ip ? "R6 pending" : "R5 pending", 64'(src_pending[s]), 64'(lv || refire));
          check("R6 dest", 64'(src_dest[s*DW +: DW]), 64'(ip ? (d & ~(32'h1 << t)) : d));
        end
      end
    end

    // R2 spurious by priority below, equal, and inactive source
    begin
      logic [IW-1:0] keep;
      keep = svc_src[1*IW +: IW];
      set_src(2, 10, 1'b0, 1'b0); tgt_ctp[7:4] = 4'd15;
      do_trig(2); do_raise(1, 2);
      ack_rd = 1; ack_tgt = 1; ack_src = 2; #0.5;
      check("R2 low prio vec", 64'(ack_vec), 64'hFF);
      check("R2 low prio flag", 64'(ack_spur), 1);
      step();
      check("R2 active clr", 64'(src_active[2]), 0);
      check("R2 svc kept", 64'(svc_src[1*IW +: IW]), 64'(keep));
      check("R4 raised clr spur", 64'(tgt_raised[1*NS+2]), 0);
      set_src(3, 15, 1'b1, 1'b0);
      do_trig(3); do_raise(1, 3);
      ack_rd = 1; ack_tgt = 1; ack_src = 3; #0.5;
      check("R2 equal prio flag", 64'(ack_spur), 1);
      step();
      check("R2 level active clr", 64'(src_active[3]), 0);
      check("R2 level pending kept", 64'(src_pending[3]), 1);
      tgt_ctp = '0;
      ack_tgt = 1; ack_src = 2; #0.5;
      check("R2 inactive flag", 64'(ack_spur), 1);
      check("R2 inactive vec", 64'(ack_vec), 64'hFF);
    end

    // R3 no-interrupt index
    begin
      logic [NS-1:0] a0, p0;
      logic [NT*NS-1:0] r0;
      logic [NS*DW-1:0] d0;
      set_src(5, 20, 1'b1, 1'b0);
      do_trig(5); do_raise(0, 5);
      a0 = src_active; p0 = src_pending; r0 = tgt_raised; d0 = src_dest;
      ack_rd = 1; ack_tgt = 0; ack_src = SW'(NS); #0.5;
      check("R3 vec", 64'(ack_vec), 64'hFF);
      check("R3 flag", 64'(ack_spur), 1);
      step();
      check("R3 active", 64'(src_active), 64'(a0));
      check("R3 pending", 64'(src_pending), 64'(p0));
      check("R3 raised", 64'(tgt_raised), 64'(r0));
      check("R3 dest", 64'(src_dest[63:0]), 64'(d0[63:0]));
      check("R4 next clr none", 64'(tgt_next_vld[0]), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule